// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Classifier

This block sits on the device side of an emulated extended-data-out DRAM. A fast internal clock samples the five asynchronous control strobes: row strobe, lower and upper column strobes, write enable and output enable. Each strobe passes through a two-flop synchroniser before edge detection. The block then works out what kind of memory cycle the controller is running from the order in which the strobes change. It does not rely on their analog timing.

For each cycle it gives the array logic the following: a row latch strobe, a column latch strobe, a one-cycle operation pulse carrying an opcode, and the byte lanes that the operation touches. It also drives the tristate enable of each data byte lane separately. A 10-bit internal counter supplies the row for refreshes in which the strobes carry no address.

The two column strobes merge into one internal column strobe. That strobe is active from the first of the two falling until the last of the two rising. A state machine tracks the RAS/CAS cycle:

- ST_IDLE goes to ST_ROW on a row fall with CAS inactive (row latch), or to ST_CBR on a row fall with CAS active.
- ST_ROW and ST_PGAP go to ST_RD or ST_WR on a CAS fall, and back to ST_IDLE on a row rise. From ST_ROW that row rise is a RAS-only refresh.
- ST_RD goes to ST_WR on a WE fall (late write or read-modify-write), to ST_PGAP on a CAS rise with the row held low, to ST_HOLD on a row rise while CAS stays low, and to ST_IDLE when both rise together.
- ST_WR goes to ST_PGAP or ST_IDLE on a CAS rise, and to ST_HOLD on a row rise.
- ST_HOLD goes to ST_HID on a row fall (hidden refresh), and to ST_IDLE on a CAS rise.
- ST_HID goes to ST_HOLD on a row rise, and to ST_CBR on a CAS rise.
- ST_CBR goes to ST_IDLE on a row rise.

Top module: `edo_strobe_decoder`

## Requirements
- R1: The internal column strobe goes active when the first of lcas_n/ucas_n falls and goes inactive only when the last of them rises. A second column strobe falling while the first is still low gives no new column latch.
- R2: A row fall while the internal column strobe is active is a CBR refresh. It gives op_code 6 with no row latch, and drive_en stays 00.
- R3: A row fall with both column strobes high gives row_latch. If the row then rises with no column strobe in between, the cycle is a RAS-only refresh: op_code 5 at the row rise, with outputs off.
- R4: The row rises and falls again while the column strobe stays low after a read. This is a hidden refresh (op_code 7), and the lanes that were read keep driving throughout.
- R5: WE low at the column fall is an early write (op_code 2). drive_en stays 00 until the column strobe rises, even if WE returns high and OE falls.
- R6: WE falls after the column fall during a read-type access. With OE high this is a late write (op_code 3). With OE low it is a read-modify-write (op_code 4). Either way drive_en drops to 00.
- R7: With WE high, a read (op_code 1) is issued at the later of the column fall and the OE fall. It is issued once per column cycle.
- R8: drive_en[0] (lower byte) and drive_en[1] (upper byte) are each 1 only in a read window with that lane's own column strobe low, OE low and WE high.
- R9: A second or later column fall within one row-low period is a page access. It gives col_latch without row_latch, with page opcodes 8 (read) and 9 (early write).
- R10: ref_row gives the refresh row. It steps by one when each CBR or hidden refresh ends (row rise) and wraps from 1023 to 0.
- R11: Outputs reflect a pin change on the third rising clock edge after it. row_latch, col_latch and op_code last exactly one cycle.
- R12: Reset, at any time, clears every output. This includes drive_en and the refresh row.
- R13: op_lanes reports {upper, lower} column strobe activity for access opcodes 1, 2, 3, 4, 8 and 9, and 00 for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_latch | output | 1 | One-cycle pulse: capture the row address |
| col_latch | output | 1 | One-cycle pulse: capture the column address |
| op_code | output | 4 | Operation pulse: 0 none, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 RAS-only refresh, 6 CBR, 7 hidden refresh, 8 page read, 9 page early write |
| op_lanes | output | 2 | Byte lanes of the access, {upper, lower} |
| drive_en | output | 2 | Per-lane tristate enable, {upper, lower} |
| ref_row | output | ROW_W | Internal refresh row counter |

## Verification
The hardest state to reach is a hidden refresh. It needs a completed read, then a row rise with the column strobe still low, then a second row fall, all without the column strobe ever rising. The stimulus table walks that exact order and checks that both lanes keep driving through every step. The refresh row wrap needs more than a thousand CBR cycles, so a directed loop alternates the row strobe with the column strobe held low until the counter passes 1023.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_READ    = 4'd1,
        OP_EWRITE  = 4'd2,
        OP_LWRITE  = 4'd3,
        OP_RMW     = 4'd4,
        OP_RONLY   = 4'd5,
        OP_CBR     = 4'd6,
        OP_HIDDEN  = 4'd7,
        OP_PGREAD  = 4'd8,
        OP_PGWRITE = 4'd9
    } dram_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROW, ST_PGAP, ST_RD, ST_WR, ST_HOLD, ST_HID, ST_CBR
    } dec_state_e;

    localparam int PIN_W = 5;

    function automatic logic is_access(input dram_op_e op);
        return (op == OP_READ)   || (op == OP_EWRITE) || (op == OP_LWRITE) ||
               (op == OP_RMW)    || (op == OP_PGREAD) || (op == OP_PGWRITE);
    endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    // each strobe idles high, so both stages reset to 1
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= pin_i[i];
                stab_q <= meta_q;
            end
        end
        assign pin_o[i] = stab_q;
    end
endmodule

// File: rtl/strobe_edges.sv
module strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_s,
    input  logic lcas_s,
    input  logic ucas_s,
    input  logic we_s,
    input  logic oe_s,
    output logic cas_act,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic cas_rise,
    output logic we_fall,
    output logic oe_fall
);
    logic ras_q, cas_q, we_q, oe_q;

    // merged column strobe: active while either lane strobe is low
    assign cas_act = ~lcas_s | ~ucas_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b0;
            we_q  <= 1'b1;
            oe_q  <= 1'b1;
        end else begin
            ras_q <= ras_s;
            cas_q <= cas_act;
            we_q  <= we_s;
            oe_q  <= oe_s;
        end
    end

    assign ras_fall = ras_q & ~ras_s;
    assign ras_rise = ~ras_q & ras_s;
    assign cas_fall = cas_act & ~cas_q;
    assign cas_rise = ~cas_act & cas_q;
    assign we_fall  = we_q & ~we_s;
    assign oe_fall  = oe_q & ~oe_s;
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == '1) |=> (count == '0));                        // R10
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != '1) |=> (count == $past(count) + 1'b1));       // R10
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));                                        // R10
endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
    import edo_dec_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             lcas_n,
    input  logic             ucas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic             row_latch,
    output logic             col_latch,
    output logic [3:0]       op_code,
    output logic [1:0]       op_lanes,
    output logic [1:0]       drive_en,
    output logic [ROW_W-1:0] ref_row
);
    logic [PIN_W-1:0] sync_v;
    logic ras_s, lcas_s, ucas_s, we_s, oe_s;
    logic cas_act, ras_fall, ras_rise, cas_fall, cas_rise, we_fall, oe_fall;

    strobe_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ras_n, lcas_n, ucas_n, we_n, oe_n}),
        .pin_o (sync_v)
    );
    assign {ras_s, lcas_s, ucas_s, we_s, oe_s} = sync_v;

    strobe_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_s    (ras_s),
        .lcas_s   (lcas_s),
        .ucas_s   (ucas_s),
        .we_s     (we_s),
        .oe_s     (oe_s),
        .cas_act  (cas_act),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall),
        .cas_rise (cas_rise),
        .we_fall  (we_fall),
        .oe_fall  (oe_fall)
    );

    dec_state_e st_q, st_n;
    logic       rd_q, rd_n;      // a read has been issued in this column cycle
    logic       pg_q, pg_n;      // current column cycle is a page cycle
    dram_op_e   op_n;
    logic       row_n, col_n, ref_inc;
    logic [1:0] lanes_now, lanes_n, drive_n;

    assign lanes_now = {~ucas_s, ~lcas_s};

    // next-state and next-output decode
    always_comb begin
        st_n    = st_q;
        rd_n    = rd_q;
        pg_n    = pg_q;
        op_n    = OP_NONE;
        row_n   = 1'b0;
        col_n   = 1'b0;
        ref_inc = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (cas_act) begin
                        st_n = ST_CBR;
                        op_n = OP_CBR;
                    end else begin
                        st_n  = ST_ROW;
                        row_n = 1'b1;
                        rd_n  = 1'b0;
                        pg_n  = 1'b0;
                    end
                end
            end
            ST_ROW, ST_PGAP: begin
                if (ras_rise) begin
                    st_n = ST_IDLE;
                    if (st_q == ST_ROW) op_n = OP_RONLY;
                end else if (cas_fall) begin
                    col_n = 1'b1;
                    pg_n  = (st_q == ST_PGAP);
                    rd_n  = 1'b0;
                    if (!we_s) begin
                        st_n = ST_WR;
                        op_n = (st_q == ST_PGAP) ? OP_PGWRITE : OP_EWRITE;
                    end else begin
                        st_n = ST_RD;
                        if (!oe_s) begin
                            op_n = (st_q == ST_PGAP) ? OP_PGREAD : OP_READ;
                            rd_n = 1'b1;
                        end
                    end
                end
            end
            ST_RD: begin
                if (cas_rise) begin
                    st_n = ras_s ? ST_IDLE : ST_PGAP;
                end else if (ras_rise) begin
                    st_n = ST_HOLD;
                end else if (we_fall) begin
                    st_n = ST_WR;
                    op_n = oe_s ? OP_LWRITE : OP_RMW;
                    rd_n = 1'b0;
                end else if (oe_fall && !rd_q) begin
                    op_n = pg_q ? OP_PGREAD : OP_READ;
                    rd_n = 1'b1;
                end
            end
            ST_WR: begin
                if (cas_rise)      st_n = ras_s ? ST_IDLE : ST_PGAP;
                else if (ras_rise) st_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (cas_rise) begin
                    st_n = ST_IDLE;
                end else if (ras_fall) begin
                    st_n = ST_HID;
                    op_n = OP_HIDDEN;
                end
            end
            ST_HID: begin
                if (ras_rise) begin
                    st_n    = cas_rise ? ST_IDLE : ST_HOLD;
                    ref_inc = 1'b1;
                end else if (cas_rise) begin
                    st_n = ST_CBR;
                end
            end
            ST_CBR: begin
                if (ras_rise) begin
                    st_n    = ST_IDLE;
                    ref_inc = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        lanes_n = is_access(op_n) ? lanes_now : 2'b00;
        drive_n = (rd_n && (st_n inside {ST_RD, ST_HOLD, ST_HID}) && !oe_s && we_s)
                  ? lanes_now : 2'b00;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            rd_q <= 1'b0;
            pg_q <= 1'b0;
        end else begin
            st_q <= st_n;
            rd_q <= rd_n;
            pg_q <= pg_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_latch <= 1'b0;
            col_latch <= 1'b0;
            op_code   <= OP_NONE;
            op_lanes  <= 2'b00;
            drive_en  <= 2'b00;
        end else begin
            row_latch <= row_n;
            col_latch <= col_n;
            op_code   <= op_n;
            op_lanes  <= lanes_n;
            drive_en  <= drive_n;
        end
    end

    refresh_row_ctr #(.ROW_W(ROW_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .count (ref_row)
    );

    AST_CBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_CBR) |-> (!row_latch && drive_en == 2'b00));           // R2
    AST_RONLY_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_RONLY) |-> (!col_latch && drive_en == 2'b00));         // R3
    AST_EWRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_EWRITE || op_code == OP_PGWRITE) |-> (drive_en == 2'b00)); // R5
    AST_LANE_LO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en[0] |-> ($past(lcas_n, 3) == 1'b0));                           // R8
    AST_LANE_HI_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en[1] |-> ($past(ucas_n, 3) == 1'b0));                           // R8
    AST_ROW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        row_latch |=> !row_latch);                                             // R11
    AST_LANES_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_lanes != 2'b00) |-> (op_code != OP_NONE && op_code != OP_CBR &&
                                 op_code != OP_HIDDEN && op_code != OP_RONLY)); // R13
endmodule

// File: tb/edo_strobe_decoder_bench.sv
module edo_strobe_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic       row_latch, col_latch;
    logic [3:0] op_code;
    logic [1:0] op_lanes, drive_en;
    logic [9:0] ref_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    edo_strobe_decoder u_edo_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .row_latch(row_latch), .col_latch(col_latch),
        .op_code(op_code), .op_lanes(op_lanes), .drive_en(drive_en), .ref_row(ref_row)
    );

    // pins: {ras_n, lcas_n, ucas_n, we_n, oe_n}; drv/lanes: {upper, lower}
    typedef struct packed {
        logic [4:0] pins;
        logic [3:0] op;
        logic       row;
        logic       col;
        logic [1:0] drv;
        logic [1:0] lanes;
        logic [9:0] rr;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        // word read then page read of upper byte: R7 R8 R9 R13
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd7},
        '{5'b00010, 4'd1, 1'b0, 1'b1, 2'b11, 2'b11, 10'd0, 4'd7},
        '{5'b01110, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd8},
        '{5'b01010, 4'd8, 1'b0, 1'b1, 2'b10, 2'b10, 10'd0, 4'd9},
        '{5'b01111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd9},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd9},
        // early write, page early write: R5 R9
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd5},
        '{5'b00001, 4'd2, 1'b0, 1'b1, 2'b00, 2'b11, 10'd0, 4'd5},
        '{5'b00010, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd5},
        '{5'b01111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd5},
        '{5'b00001, 4'd9, 1'b0, 1'b1, 2'b00, 2'b11, 10'd0, 4'd9},
        '{5'b01111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd5},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd5},
        // OE-controlled late write: R6
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd6},
        '{5'b00011, 4'd0, 1'b0, 1'b1, 2'b00, 2'b00, 10'd0, 4'd6},
        '{5'b00001, 4'd3, 1'b0, 1'b0, 2'b00, 2'b11, 10'd0, 4'd6},
        '{5'b01111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd6},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd6},
        // read-modify-write: R6
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd6},
        '{5'b00010, 4'd1, 1'b0, 1'b1, 2'b11, 2'b11, 10'd0, 4'd6},
        '{5'b00000, 4'd4, 1'b0, 1'b0, 2'b00, 2'b11, 10'd0, 4'd6},
        '{5'b01111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd6},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd6},
        // lower-byte read started by OE fall: R7 R8 R13
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd7},
        '{5'b00111, 4'd0, 1'b0, 1'b1, 2'b00, 2'b00, 10'd0, 4'd7},
        '{5'b00110, 4'd1, 1'b0, 1'b0, 2'b01, 2'b01, 10'd0, 4'd13},
        '{5'b01111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd8},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd8},
        // column strobe merge: R1
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd1},
        '{5'b00111, 4'd0, 1'b0, 1'b1, 2'b00, 2'b00, 10'd0, 4'd1},
        '{5'b00011, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd1},
        '{5'b01011, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd1},
        '{5'b01010, 4'd1, 1'b0, 1'b0, 2'b10, 2'b10, 10'd0, 4'd1},
        '{5'b01110, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd1},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd1},
        // RAS-only refresh: R3
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd0, 4'd3},
        '{5'b11111, 4'd5, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd3},
        // CBR refresh: R2 R10
        '{5'b10011, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd2},
        '{5'b00011, 4'd6, 1'b0, 1'b0, 2'b00, 2'b00, 10'd0, 4'd2},
        '{5'b10011, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd1, 4'd10},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd1, 4'd2},
        // hidden refresh after a read: R4
        '{5'b01111, 4'd0, 1'b1, 1'b0, 2'b00, 2'b00, 10'd1, 4'd4},
        '{5'b00010, 4'd1, 1'b0, 1'b1, 2'b11, 2'b11, 10'd1, 4'd4},
        '{5'b10010, 4'd0, 1'b0, 1'b0, 2'b11, 2'b00, 10'd1, 4'd4},
        '{5'b00010, 4'd7, 1'b0, 1'b0, 2'b11, 2'b00, 10'd1, 4'd4},
        '{5'b10010, 4'd0, 1'b0, 1'b0, 2'b11, 2'b00, 10'd2, 4'd4},
        '{5'b11111, 4'd0, 1'b0, 1'b0, 2'b00, 2'b00, 10'd2, 4'd4}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] p);
        {ras_n, lcas_n, ucas_n, we_n, oe_n} = p;
    endtask

    // R11: outputs reflect a pin change on the third rising edge
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12", "reset op", int'(op_code), 0);
        check("R12", "reset drive", int'(drive_en), 0);
        check("R12", "reset ref_row", int'(ref_row), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string r;
            r = $sformatf("R%0d", VEC[i].req);
            apply(VEC[i].pins);
            settle();
            check(r, $sformatf("step %0d op_code", i),   int'(op_code),   int'(VEC[i].op));
            check(r, $sformatf("step %0d row_latch", i), int'(row_latch), int'(VEC[i].row));
            check(r, $sformatf("step %0d col_latch", i), int'(col_latch), int'(VEC[i].col));
            check(r, $sformatf("step %0d drive_en", i),  int'(drive_en),  int'(VEC[i].drv));
            check(r, $sformatf("step %0d op_lanes", i),  int'(op_lanes),  int'(VEC[i].lanes));
            check(r, $sformatf("step %0d ref_row", i),   int'(ref_row),   int'(VEC[i].rr));
        end

        // R11: pulses last one cycle
        apply(5'b01111);
        settle();
        check("R11", "row pulse present", int'(row_latch), 1);
        @(negedge clk);
        check("R11", "row pulse gone", int'(row_latch), 0);
        apply(5'b11111);
        settle();
        check("R11", "ras-only op pulse", int'(op_code), 5);
        @(negedge clk);
        check("R11", "op pulse gone", int'(op_code), 0);

        // R10: counter wrap through repeated CBR cycles, counter is at 2 here
        apply(5'b10011);
        settle();
        for (int k = 0; k < 1021; k++) begin
            apply(5'b00011);
            settle();
            apply(5'b10011);
            settle();
        end
        check("R10", "ref_row before wrap", int'(ref_row), 1023);
        apply(5'b00011);
        settle();
        check("R10", "cbr op at row 1023", int'(op_code), 6);
        check("R10", "ref_row during last cbr", int'(ref_row), 1023);
        apply(5'b10011);
        settle();
        check("R10", "ref_row after wrap", int'(ref_row), 0);
        apply(5'b11111);
        settle();

        // R12: reset in the middle of a driving read
        apply(5'b01111);
        settle();
        apply(5'b00010);
        settle();
        check("R12", "drive before reset", int'(drive_en), 3);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "drive after reset", int'(drive_en), 0);
        check("R12", "op after reset", int'(op_code), 0);
        apply(5'b11111);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R12", "drive after release", int'(drive_en), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule